// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a soft, runtime-configurable two-level logic array. Every input is split into a true line and an inverted line. A bank of product terms ANDs any chosen set of those lines (the AND plane). A bank of outputs ORs any chosen set of the product terms (the OR plane). The configuration of both planes, called the personality, is held in flip-flops and loaded one word at a time through a small addressed write port. Any product term can feed any number of outputs, so a shared term is built only once.

Data flows from `in_vec` to `out_comb` through gates only, with no register on the way. `out_reg` is a copy of `out_comb` taken at each clock edge. After reset the array is unprogrammed: every term is connected to both lines of every input, so every term is 0. No term is connected to any output.

Top module: `sop_array`

## Requirements
- R1: Input `in_vec[i]` is offered to every term on a true line and on an inverted line. In the selector word of a term, the 2-bit field at bits [2i+1:2i] controls input i. The code 2'b01 uses the true line, so the term needs `in_vec[i]`=1. The code 2'b10 uses the inverted line, so the term needs `in_vec[i]`=0.
- R2: The selector code 2'b00 removes input i from the term. A term whose fields are all 2'b00 evaluates to 1.
- R3: The selector code 2'b11 connects both lines of input i. The term is then 0 for every input value.
- R4: In the OR-row word of output j, bit t set to 1 ORs term t into `out_comb[j]`. Bit t set to 0 leaves term t out. An output whose row is all zero is 0.
- R5: One term may be connected into several outputs at once. With terms P0=x1x2, P1=x1x3', P2=x1'x2'x3 and P3=x1x3, where x1, x2 and x3 are `in_vec[0]`, `in_vec[1]` and `in_vec[2]`, the rows 4'b0111 and 4'b1101 give f1=x1x2+x1x3'+x1'x2'x3 and f2=x1x2+x1'x2'x3+x1x3 for all 8 inputs.
- R6: A synchronous active-low reset loads 2'b11 into every selector field and clears every OR-row bit. After reset, `out_comb` and `out_reg` are 0 for all inputs.
- R7: Address t (0 to N_TERM-1) writes the selector word of term t from `cfg_wdata[2*N_IN-1:0]`. Address N_TERM+j writes the OR row of output j from `cfg_wdata[N_TERM-1:0]`. A write to an address at or above N_TERM+N_OUT changes nothing.
- R8: A write with `cfg_we`=1 takes effect at the next rising clock edge. Before that edge `out_comb` still shows the old personality, and after it `out_comb` shows the new one. While `cfg_we`=0, changes on `cfg_addr` and `cfg_wdata` have no effect.
- R9: `out_comb` follows `in_vec` within the same cycle. `out_reg` takes the value of `out_comb` at each rising edge and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Personality write strobe |
| cfg_addr | input | ADDR_W | Term or output-row address |
| cfg_wdata | input | DATA_W | Selector word or OR-row word |
| in_vec | input | N_IN | Logic inputs |
| out_comb | output | N_OUT | Sum-of-products outputs, no register |
| out_reg | output | N_OUT | `out_comb` registered at the clock edge |

## Verification
The results fall due at three different times.
- `out_comb` answers a new `in_vec` in the same cycle. The bench drives inputs on the falling edge and samples one nanosecond later.
- A personality write shows on `out_comb` only after the rising edge that takes the strobe. The bench samples once just before that edge, expecting the old result, and once just after it, expecting the new one.
- `out_reg` lags `out_comb` by one rising edge. Each sweep therefore reads it only after the next rising edge, compares it with the value expected for the input held over that edge, and also checks that it has not yet moved before the edge.

// File: rtl/sop_pkg.sv
// Package sop_pkg
// Holds the literal-selector encoding shared by the personality registers,
// the AND plane and the checker. Assumes two selector bits per input.
package sop_pkg;

    // Literal selector: bit0 connects the true line, bit1 the inverted line
    typedef enum logic [1:0] {
        LIT_OFF  = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_BOTH = 2'b11
    } lit_sel_e;

    localparam int SEL_W = 2;

    // One literal's contribution to a product term: 0 blocks the term
    function automatic logic lit_pass(input logic [SEL_W-1:0] sel, input logic x);
        logic true_line;
        logic comp_line;
        true_line = x;
        comp_line = ~x;
        return (~sel[0] | true_line) & (~sel[1] | comp_line);
    endfunction

endpackage

// File: rtl/sop_wr_decode.sv
// Module sop_wr_decode
// Turns the addressed write port into one write strobe per term register
// and one per OR-row register. Assumes N_TERM+N_OUT fits in ADDR_W bits.
// Addresses with no matching register raise no strobe.
module sop_wr_decode #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    parameter int ADDR_W = 3
) (
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [N_TERM-1:0] term_wr,
    output logic [N_OUT-1:0]  row_wr
);

    // One strobe per product-term selector word
    for (genvar t = 0; t < N_TERM; t++) begin : g_term_dec
        localparam logic [ADDR_W-1:0] TERM_ADDR = ADDR_W'(t);
        assign term_wr[t] = cfg_we && (cfg_addr == TERM_ADDR);
    end

    // One strobe per output OR row, placed after the term words
    for (genvar j = 0; j < N_OUT; j++) begin : g_row_dec
        localparam logic [ADDR_W-1:0] ROW_ADDR = ADDR_W'(N_TERM + j);
        assign row_wr[j] = cfg_we && (cfg_addr == ROW_ADDR);
    end

endmodule

// File: rtl/sop_cfg_regs.sv
// Module sop_cfg_regs
// Personality storage for both planes. The selector words and OR rows are
// brought out as flat vectors. Reset leaves the array unprogrammed: all
// selectors at LIT_BOTH and all OR bits clear. Assumes DATA_W >= 2*N_IN and
// DATA_W >= N_TERM.
module sop_cfg_regs
    import sop_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    parameter int DATA_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_TERM-1:0]           term_wr,
    input  logic [N_OUT-1:0]            row_wr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [N_TERM*2*N_IN-1:0]    term_cfg,
    output logic [N_OUT*N_TERM-1:0]     or_cfg
);

    localparam int TW = SEL_W * N_IN;

    // Selector word of every product term
    for (genvar t = 0; t < N_TERM; t++) begin : g_term_reg
        logic [TW-1:0] sel_q;

        // Load the term's selectors; reset connects both lines of each input
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q <= {N_IN{LIT_BOTH}};
            end else if (term_wr[t]) begin
                sel_q <= cfg_wdata[TW-1:0];
            end
        end

        assign term_cfg[t*TW +: TW] = sel_q;
    end

    // OR-plane row of every output
    for (genvar j = 0; j < N_OUT; j++) begin : g_row_reg
        logic [N_TERM-1:0] row_q;

        // Load the output's term connections; reset disconnects all terms
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (row_wr[j]) begin
                row_q <= cfg_wdata[N_TERM-1:0];
            end
        end

        assign or_cfg[j*N_TERM +: N_TERM] = row_q;
    end

endmodule

// File: rtl/sop_and_plane.sv
// Module sop_and_plane
// Programmable AND plane. Each term ANDs the literals its selector word
// picks from the true and inverted input lines. Purely combinational. A term
// with no connected literal is 1.
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4
) (
    input  logic [N_IN-1:0]             in_vec,
    input  logic [N_TERM*2*N_IN-1:0]    term_cfg,
    output logic [N_TERM-1:0]           term_val
);

    localparam int TW = SEL_W * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [TW-1:0] sel_w;
        assign sel_w = term_cfg[t*TW +: TW];

        // Wide AND over every input's literal pass value
        always_comb begin
            term_val[t] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                term_val[t] = term_val[t] & lit_pass(sel_w[i*SEL_W +: SEL_W], in_vec[i]);
            end
        end
    end

endmodule

// File: rtl/sop_or_plane.sv
// Module sop_or_plane
// Programmable OR plane. Each output ORs the terms its row marks. Any term
// may feed any number of outputs. Purely combinational. An empty row gives 0.
module sop_or_plane #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2
) (
    input  logic [N_TERM-1:0]       term_val,
    input  logic [N_OUT*N_TERM-1:0] or_cfg,
    output logic [N_OUT-1:0]        sum_val
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_sum
        assign sum_val[j] = |(term_val & or_cfg[j*N_TERM +: N_TERM]);
    end

endmodule

// File: rtl/sop_array.sv
// Module sop_array
// Top of the programmable sum-of-products array. The write decoder and the
// personality registers feed the combinational AND and OR planes, and a
// register copies the outputs. Assumes N_TERM+N_OUT >= 2 so that the address
// is at least one bit wide.
module sop_array #(
    parameter  int N_IN   = 3,
    parameter  int N_TERM = 4,
    parameter  int N_OUT  = 2,
    localparam int ADDR_W = $clog2(N_TERM + N_OUT),
    localparam int DATA_W = (2 * N_IN > N_TERM) ? 2 * N_IN : N_TERM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_comb,
    output logic [N_OUT-1:0]  out_reg
);

    logic [N_TERM-1:0]        term_wr;
    logic [N_OUT-1:0]         row_wr;
    logic [N_TERM*2*N_IN-1:0] term_cfg;
    logic [N_OUT*N_TERM-1:0]  or_cfg;
    logic [N_TERM-1:0]        term_val;

    sop_wr_decode #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .term_wr  (term_wr),
        .row_wr   (row_wr)
    );

    sop_cfg_regs #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .term_wr   (term_wr),
        .row_wr    (row_wr),
        .cfg_wdata (cfg_wdata),
        .term_cfg  (term_cfg),
        .or_cfg    (or_cfg)
    );

    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) u_and (
        .in_vec   (in_vec),
        .term_cfg (term_cfg),
        .term_val (term_val)
    );

    sop_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT)
    ) u_or (
        .term_val (term_val),
        .or_cfg   (or_cfg),
        .sum_val  (out_comb)
    );

    // Registered copy of the combinational outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_reg <= '0;
        end else begin
            out_reg <= out_comb;
        end
    end

endmodule

// File: rtl/sop_array_chk.sv
// Module sop_array_chk
// Assertion checker bound into sop_array. It watches the ports and the
// OR-row registers. It keeps one flag of its own that records whether any
// write has been seen since reset.
module sop_array_chk #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    parameter int ADDR_W = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [ADDR_W-1:0]         cfg_addr,
    input logic [N_IN-1:0]           in_vec,
    input logic [N_OUT-1:0]          out_comb,
    input logic [N_OUT-1:0]          out_reg,
    input logic [N_OUT*N_TERM-1:0]   or_cfg
);

    logic wrote_q;

    // Remember whether any personality write has been issued since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
        end else if (cfg_we) begin
            wrote_q <= 1'b1;
        end
    end

    // R6: an unprogrammed array drives 0 on every output
    p_unprog_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrote_q |-> (out_comb == '0 && out_reg == '0));

    // R9: the registered outputs lag the combinational ones by one edge
    p_reg_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_reg == $past(out_comb)));

    // R8: with no write and steady inputs, the outputs hold
    p_hold_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(in_vec) -> $stable(out_comb)));

    // R9: outputs never carry unknown values out of reset
    p_known_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_comb) && !$isunknown(out_reg));

    // R4: an output with an empty row is 0
    for (genvar j = 0; j < N_OUT; j++) begin : g_row_chk
        p_empty_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (or_cfg[j*N_TERM +: N_TERM] == '0) |-> !out_comb[j]);
    end

    // R7: the address port carries no unknown value while a write is strobed
    p_addr_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> !$isunknown(cfg_addr));

endmodule

bind sop_array sop_array_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .in_vec   (in_vec),
    .out_comb (out_comb),
    .out_reg  (out_reg),
    .or_cfg   (or_cfg)
);

// File: tb/sop_array_tb.sv
module sop_array_tb;

    localparam int N  = 3;
    localparam int K  = 4;
    localparam int M  = 2;
    localparam int AW = 3;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [DW-1:0] cfg_wdata;
    logic [N-1:0]  in_vec;
    logic [M-1:0]  out_comb;
    logic [M-1:0]  out_reg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench-side copy of the personality, updated from R6/R7 rules
    logic [2*N-1:0] m_term [K];
    logic [K-1:0]   m_or   [M];

    always #4 clk = ~clk;  // 125 MHz

    sop_array #(.N_IN(N), .N_TERM(K), .N_OUT(M)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_vec    (in_vec),
        .out_comb  (out_comb),
        .out_reg   (out_reg)
    );

    function automatic logic [M-1:0] ref_eval(input logic [N-1:0] x);
        logic [M-1:0] r;
        logic [K-1:0] p;
        for (int t = 0; t < K; t++) begin
            p[t] = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (m_term[t][2*i]   && !x[i]) p[t] = 1'b0;
                if (m_term[t][2*i+1] &&  x[i]) p[t] = 1'b0;
            end
        end
        for (int j = 0; j < M; j++) r[j] = |(p & m_or[j]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
        if (a < K) m_term[a] = d[2*N-1:0];
        else if (a < K + M) m_or[a - K] = d[K-1:0];
    endtask

    // Drive every input pattern; check out_comb same cycle, out_reg after the edge
    task automatic sweep(input string req);
        for (int v = 0; v < (1 << N); v++) begin
            logic [M-1:0] e;
            logic [M-1:0] prev_reg;
            @(negedge clk);
            prev_reg = out_reg;
            in_vec = N'(v);
            e = ref_eval(N'(v));
            #1 chk(req, out_comb, e);
            chk({req, " out_reg held before edge"}, out_reg, prev_reg);
            @(posedge clk);
            #1 chk({req, " out_reg"}, out_reg, e);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; in_vec = '0;
        for (int t = 0; t < K; t++) m_term[t] = '1;
        for (int j = 0; j < M; j++) m_or[j] = '0;
        repeat (3) @(posedge clk);
        #1 chk("R6 out_reg in reset", out_reg, '0);
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R6 unprogrammed");
        cfg_write(AW'(K), 6'b00_1111);
        cfg_write(AW'(K + 1), 6'b00_1111);
        sweep("R6 both-literal terms stay 0");
    endtask

    task automatic t_single_literal();
        cfg_write(AW'(0), 6'b00_01_00);  // x2 true
        cfg_write(AW'(1), 6'b10_00_00);  // x3 inverted
        cfg_write(AW'(K), 6'b00_0001);
        cfg_write(AW'(K + 1), 6'b00_0010);
        @(negedge clk); in_vec = 3'b010;
        #1 chk("R1 x2=1 x3=0", out_comb, 2'b11);
        @(negedge clk); in_vec = 3'b101;
        #1 chk("R1 x2=0 x3=1", out_comb, 2'b00);
        sweep("R1 literal lines");
    endtask

    task automatic t_absent_both();
        cfg_write(AW'(0), 6'b00_00_00);
        cfg_write(AW'(1), 6'b00_00_11);
        sweep("R2 R3 absent and both");
        @(negedge clk); in_vec = 3'b110;
        #1 chk("R2 all-absent term is 1 / R3 both-lines term is 0", out_comb, 2'b01);
    endtask

    task automatic t_empty_row();
        cfg_write(AW'(K + 1), 6'b00_0000);
        for (int v = 0; v < (1 << N); v++) begin
            @(negedge clk); in_vec = N'(v);
            #1 chk("R4 empty row gives 0", {out_comb[1], 1'b0}, 2'b00);
        end
    endtask

    task automatic t_shared_terms();
        cfg_write(AW'(0), 6'b00_01_01);  // x1 x2
        cfg_write(AW'(1), 6'b10_00_01);  // x1 x3'
        cfg_write(AW'(2), 6'b01_10_10);  // x1' x2' x3
        cfg_write(AW'(3), 6'b01_00_01);  // x1 x3
        cfg_write(AW'(K), 6'b00_0111);
        cfg_write(AW'(K + 1), 6'b00_1101);
        for (int v = 0; v < 8; v++) begin
            logic x1, x2, x3;
            logic [1:0] e;
            x1 = v[0]; x2 = v[1]; x3 = v[2];
            e[0] = (x1 & x2) | (x1 & ~x3) | (~x1 & ~x2 & x3);
            e[1] = (x1 & x2) | (~x1 & ~x2 & x3) | (x1 & x3);
            @(negedge clk); in_vec = 3'(v);
            #1 chk("R5 shared-term functions", out_comb, e);
        end
        sweep("R5 model sweep");
    endtask

    task automatic t_bad_addr();
        cfg_write(AW'(6), 6'b11_1111);
        cfg_write(AW'(7), 6'b00_0000);
        sweep("R7 out-of-range writes ignored");
    endtask

    task automatic t_write_timing();
        @(negedge clk); in_vec = 3'b011;         // f1=1 f2=1 with shared-term set
        #1 chk("R8 baseline", out_comb, 2'b11);
        cfg_addr = AW'(K); cfg_wdata = 6'b00_0000;  // strobe low: nothing may change
        @(posedge clk); #1 chk("R8 no write without strobe", out_comb, 2'b11);
        @(negedge clk); cfg_we = 1'b1;
        #2 chk("R8 old value before edge", out_comb, 2'b11);
        @(posedge clk); #1 cfg_we = 1'b0;
        m_or[0] = '0;
        chk("R8 new value after edge", out_comb, 2'b10);
    endtask

    task automatic t_outreg();
        @(negedge clk); in_vec = 3'b000;
        @(posedge clk);
        @(negedge clk); in_vec = 3'b011;
        #1 chk("R9 comb same cycle", out_comb, 2'b10);
        chk("R9 reg not yet updated", out_reg, 2'b00);
        @(posedge clk); #1 chk("R9 reg one edge later", out_reg, 2'b10);
    endtask

    initial begin
        t_reset();
        t_single_literal();
        t_absent_both();
        t_empty_row();
        t_shared_terms();
        t_bad_addr();
        t_write_timing();
        t_outreg();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule